// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is an SPI master that works through a small internal queue without processor help. Each queue entry holds a transmit word, a receive word and a seven-bit command. The command carries the chip-select code, a hold flag, a length-select flag and a delay-select flag. After a start pulse the sequencer fetches the entry named by its current pointer. It drives the chip-select code, shifts a word of 8 to 16 bits out on MOSI while collecting MISO, and writes the received word back into the entry's receive slot. It then waits out a gap before moving to the next entry.

The host reaches everything through one flat word port. Addresses 0x00-0x0F hold the transmit words, 0x10-0x1F the receive words (read only) and 0x20-0x2F the commands. The configuration registers sit at 0x30 (word length), 0x31 (delay), 0x32 (start pointer), 0x33 (end pointer), 0x34 (current pointer) and 0x35 (bit 0: wraparound). Runs can stop at the end entry, or loop from the end entry back to the start entry indefinitely. A run can also be redirected to another part of the queue while it is in flight.

The control state machine has four states. IDLE waits for a start. FETCH reads the entry. SHIFT runs the serial word. GAP is the delay or pause that follows a word. The transitions are:
- GO: IDLE to FETCH on a start pulse.
- ISSUE: FETCH to SHIFT, always.
- XFER_DONE: SHIFT to GAP when the last bit has been clocked.
- NEXT: GAP to FETCH when the gap expires and the run continues.
- FINISH: GAP to IDLE when the gap expires after the final entry.

Top module: `spiq_master`

## Requirements
- R1: After reset the outputs are cs_n = 4'hF, sck = 0, mosi = 0, done = 0 and busy = 0. The registers read back as length 8, delay 17 and current pointer 0.
- R2: Outside a transfer, cs_n is 4'hF. During an entry's shift, cs_n equals bits [3:0] of that entry's command. cs_n takes that value one clock after the fetch clock.
- R3: When command bit 5 is set, the entry uses the programmed length; when it is clear, the entry uses 8 bits. A written length below 8 is stored as 8, and one above 16 is stored as 16.
- R4: An entry of n bits takes one fetch clock and then 2*SCK_HALF*n shift clocks. Data goes out MSB first. SCK idles low, and each SCK phase lasts SCK_HALF clocks. MOSI changes with each falling SCK, and MISO is sampled at each rising SCK. The received n bits are stored right-justified in the entry's receive slot, with the upper bits cleared.
- R5: A start pulse loads the current pointer from the start pointer. When an entry is not the end entry, the pointer then steps by one after that entry's gap. The current pointer is readable at 0x34.
- R6: An entry without hold drops cs_n to 4'hF after its shift and waits a gap with SCK low. The gap is the programmed delay when command bit 6 is set, and 17 clocks when it is clear. A written delay of 0 is stored as 1.
- R7: An entry with command bit 4 set keeps its cs_n code through a 17-clock pause with SCK low, and the next entry follows directly. The hold is ignored on the entry that ends the run.
- R8: After the end entry's gap, with wraparound off, the sequencer returns to IDLE with cs_n = 4'hF and busy = 0, and sets done. done stays set until the next start pulse clears it.
- R9: With wraparound on, the end entry is followed by the start entry, and each pass overwrites the receive slots. Clearing wraparound during a pass ends the run at that pass's end entry.
- R10: A write to the current pointer while busy takes effect once the current entry's gap is over. The skipped entries keep their receive slots untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| go | input | 1 | Start pulse, used only while idle |
| done | output | 1 | Sticky run-finished flag |
| busy | output | 1 | Sequencer is running |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select code |

## Verification
The bench builds the block with SCK_HALF = 3 and keeps the 16-entry queue and the 17-clock default delay and pause. Because SCK_HALF is 3, each SCK phase spans several clocks, so a shift counter that is off by one or a sampling edge that falls on the wrong phase shows up in the cycle-by-cycle comparison. The full queue depth leaves room for separate segments for the mixed-length run, the clamp run, a wraparound pair and a redirected segment. It also leaves an untouched entry whose receive slot must stay zero.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;

    // Per-entry command: bit6 delay select, bit5 length select, bit4 hold, [3:0] cs code
    typedef struct packed {
        logic       own_dly;
        logic       own_len;
        logic       hold_cs;
        logic [3:0] cs_code;
    } entry_cmd_t;

    localparam int CMD_W = 7;

    // Host address regions (addr[5:4])
    localparam logic [1:0] RG_TX  = 2'd0;
    localparam logic [1:0] RG_RX  = 2'd1;
    localparam logic [1:0] RG_CMD = 2'd2;
    localparam logic [1:0] RG_CFG = 2'd3;

    // Configuration register indices (addr[3:0] in RG_CFG)
    localparam logic [3:0] CF_LEN   = 4'd0;
    localparam logic [3:0] CF_DLY   = 4'd1;
    localparam logic [3:0] CF_START = 4'd2;
    localparam logic [3:0] CF_END   = 4'd3;
    localparam logic [3:0] CF_PTR   = 4'd4;
    localparam logic [3:0] CF_MODE  = 4'd5;

endpackage

// File: rtl/spiq_store.sv
module spiq_store
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_we,
    input  logic          cmd_we,
    input  logic [IW-1:0] host_idx,
    input  logic [DW-1:0] host_wdata,
    input  entry_cmd_t    host_cmd_wdata,
    output logic [DW-1:0] host_tx,
    output logic [DW-1:0] host_rx,
    output entry_cmd_t    host_cmd,
    input  logic [IW-1:0] eng_idx,
    output logic [DW-1:0] eng_tx,
    output entry_cmd_t    eng_cmd,
    input  logic          rx_we,
    input  logic [DW-1:0] rx_data
);

    logic [DW-1:0] tx_q  [DEPTH];
    logic [DW-1:0] rx_q  [DEPTH];
    entry_cmd_t    cmd_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tx_q[i]  <= '0;
                rx_q[i]  <= '0;
                cmd_q[i] <= '0;
            end
        end else begin
            if (tx_we)  tx_q[host_idx]  <= host_wdata;
            if (cmd_we) cmd_q[host_idx] <= host_cmd_wdata;
            if (rx_we)  rx_q[eng_idx]   <= rx_data;
        end
    end

    assign host_tx  = tx_q[host_idx];
    assign host_rx  = rx_q[host_idx];
    assign host_cmd = cmd_q[host_idx];
    assign eng_tx   = tx_q[eng_idx];
    assign eng_cmd  = cmd_q[eng_idx];

endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
    parameter int DW       = 16,
    parameter int SCK_HALF = 2,
    parameter int MIN_LEN  = 8,
    localparam int LEN_W   = $clog2(DW + 1),
    localparam int HC_W    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] nbits,
    input  logic [DW-1:0]    tx_word,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic [DW-1:0]    rx_word,
    output logic             busy,
    output logic             done_p
);

    logic [HC_W-1:0]  hcnt;
    logic [LEN_W-1:0] left;
    logic [DW-1:0]    sh;
    logic [DW-1:0]    rx;
    logic             sck_q;
    logic             busy_q;
    logic             half_end;

    generate
        if (SCK_HALF == 1) begin : g_single
            assign half_end = 1'b1;
        end else begin : g_multi
            assign half_end = (hcnt == HC_W'(SCK_HALF - 1));
        end
    endgenerate

    assign done_p = busy_q && half_end && sck_q && (left == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            left   <= '0;
            sh     <= '0;
            rx     <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (start) begin
            hcnt   <= '0;
            left   <= nbits;
            sh     <= tx_word << (DW - int'(nbits));
            rx     <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (half_end) begin
                hcnt  <= '0;
                sck_q <= ~sck_q;
                if (!sck_q) begin
                    rx <= {rx[DW-2:0], miso};
                end else begin
                    sh   <= sh << 1;
                    left <= left - LEN_W'(1);
                    if (left == LEN_W'(1)) busy_q <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + HC_W'(1);
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh[DW-1];
    assign rx_word = rx;
    assign busy    = busy_q;

    // R3: every launched word has a legal length
    a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (nbits >= LEN_W'(MIN_LEN) && nbits <= LEN_W'(DW)));

    // R4: serial clock rests low whenever no word is being shifted
    a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    // R4: a word ends only on a falling serial clock edge
    a_r4_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> (!sck_q && !busy_q));

endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
    import spiq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 16,
    parameter int DLY_W    = 14,
    parameter int PAUSE    = 17,
    parameter int DEF_DLY  = 17,
    parameter int MIN_LEN  = 8,
    localparam int IW      = $clog2(DEPTH),
    localparam int LEN_W   = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IW-1:0]    start_ptr,
    input  logic [IW-1:0]    end_ptr,
    input  logic             wrap_en,
    input  logic [LEN_W-1:0] len_cfg,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic             ptr_we,
    input  logic [IW-1:0]    ptr_wdata,
    input  entry_cmd_t       eng_cmd,
    input  logic             sh_done,
    output logic [IW-1:0]    cur_ptr,
    output logic             sh_start,
    output logic [LEN_W-1:0] sh_nbits,
    output logic             rx_we,
    output logic [3:0]       cs_n,
    output logic             done,
    output logic             busy
);

    seq_state_t       state_q, state_d;
    logic [IW-1:0]    ptr_q;
    logic             pend_v;
    logic [IW-1:0]    pend_ptr;
    logic [DLY_W-1:0] gap_cnt;
    logic             hold_q;
    logic             own_dly_q;
    logic [3:0]       cs_q;
    logic             done_q;
    logic             gap_end;
    logic             at_last;
    logic             keep_cs;

    assign gap_end = (state_q == ST_GAP) && (gap_cnt == DLY_W'(1));
    assign at_last = !pend_v && !ptr_we && (ptr_q == end_ptr) && !wrap_en;
    assign keep_cs = hold_q && !at_last;

    // Next-state logic: GO, ISSUE, XFER_DONE, NEXT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) state_d = ST_GAP;
            ST_GAP:   if (gap_end) state_d = at_last ? ST_IDLE : ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, pointer and gap timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            pend_v    <= 1'b0;
            pend_ptr  <= '0;
            gap_cnt   <= '0;
            hold_q    <= 1'b0;
            own_dly_q <= 1'b0;
            cs_q      <= 4'hF;
            done_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cs_q <= 4'hF;
                    if (go) begin
                        ptr_q  <= start_ptr;
                        done_q <= 1'b0;
                        pend_v <= 1'b0;
                    end else if (ptr_we) begin
                        ptr_q <= ptr_wdata;
                    end
                end
                ST_FETCH: begin
                    cs_q      <= eng_cmd.cs_code;
                    hold_q    <= eng_cmd.hold_cs;
                    own_dly_q <= eng_cmd.own_dly;
                    if (ptr_we) begin
                        pend_v   <= 1'b1;
                        pend_ptr <= ptr_wdata;
                    end
                end
                ST_SHIFT: begin
                    if (ptr_we) begin
                        pend_v   <= 1'b1;
                        pend_ptr <= ptr_wdata;
                    end
                    if (sh_done) begin
                        if (keep_cs) begin
                            gap_cnt <= DLY_W'(PAUSE);
                        end else begin
                            cs_q    <= 4'hF;
                            gap_cnt <= own_dly_q ? dly_cfg : DLY_W'(DEF_DLY);
                        end
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt - DLY_W'(1);
                    if (gap_end) begin
                        pend_v <= 1'b0;
                        if (ptr_we)                  ptr_q <= ptr_wdata;
                        else if (pend_v)             ptr_q <= pend_ptr;
                        else if (ptr_q != end_ptr)   ptr_q <= ptr_q + IW'(1);
                        else if (wrap_en)            ptr_q <= start_ptr;
                        if (at_last) begin
                            done_q <= 1'b1;
                            cs_q   <= 4'hF;
                        end
                    end else if (ptr_we) begin
                        pend_v   <= 1'b1;
                        pend_ptr <= ptr_wdata;
                    end
                end
                default: cs_q <= 4'hF;
            endcase
        end
    end

    assign cur_ptr  = ptr_q;
    assign sh_start = (state_q == ST_FETCH);
    assign sh_nbits = eng_cmd.own_len ? len_cfg : LEN_W'(MIN_LEN);
    assign rx_we    = (state_q == ST_SHIFT) && sh_done;
    assign cs_n     = cs_q;
    assign done     = done_q;
    assign busy     = (state_q != ST_IDLE);

    // R2: no chip-select code is presented while idle
    a_r2_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cs_q == 4'hF));

    // R5: an undisturbed, non-final entry steps the pointer by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_end && !pend_v && !ptr_we && ptr_q != end_ptr)
        |=> (ptr_q == IW'($past(ptr_q) + IW'(1))));

    // R7: the chip-select code does not move during a gap
    a_r7_gap_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) == ST_GAP) |-> $stable(cs_q));

    // R8: done rises only at the end of a gap
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_GAP && state_q == ST_IDLE));

endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 16,
    parameter int DLY_W    = 14,
    parameter int SCK_HALF = 2,
    parameter int PAUSE    = 17,
    parameter int DEF_DLY  = 17,
    parameter int MIN_LEN  = 8,
    localparam int IW      = $clog2(DEPTH),
    localparam int LEN_W   = $clog2(DW + 1),
    localparam int AW      = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          go,
    output logic          done,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic [3:0]    cs_n
);

    logic [1:0]       region;
    logic [IW-1:0]    idx;
    logic [LEN_W-1:0] len_cfg;
    logic [DLY_W-1:0] dly_cfg;
    logic [IW-1:0]    start_ptr;
    logic [IW-1:0]    end_ptr;
    logic             wrap_en;
    logic             cfg_we;
    logic             ptr_we;
    logic [DW-1:0]    host_tx, host_rx;
    entry_cmd_t       host_cmd, eng_cmd;
    logic [DW-1:0]    eng_tx;
    logic [IW-1:0]    cur_ptr;
    logic             sh_start, sh_done, sh_busy, rx_we;
    logic [LEN_W-1:0] sh_nbits;
    logic [DW-1:0]    rx_word;

    assign region = host_addr[AW-1:AW-2];
    assign idx    = host_addr[IW-1:0];
    assign cfg_we = host_we && (region == RG_CFG);
    assign ptr_we = cfg_we && (idx == IW'(CF_PTR));

    // Configuration registers with length and delay clamping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_cfg   <= LEN_W'(MIN_LEN);
            dly_cfg   <= DLY_W'(DEF_DLY);
            start_ptr <= '0;
            end_ptr   <= '0;
            wrap_en   <= 1'b0;
        end else if (cfg_we) begin
            unique case (idx)
                IW'(CF_LEN): begin
                    if (host_wdata < DW'(MIN_LEN))  len_cfg <= LEN_W'(MIN_LEN);
                    else if (host_wdata > DW'(DW))  len_cfg <= LEN_W'(DW);
                    else                            len_cfg <= host_wdata[LEN_W-1:0];
                end
                IW'(CF_DLY):   dly_cfg   <= (host_wdata[DLY_W-1:0] == '0) ? DLY_W'(1)
                                                                           : host_wdata[DLY_W-1:0];
                IW'(CF_START): start_ptr <= host_wdata[IW-1:0];
                IW'(CF_END):   end_ptr   <= host_wdata[IW-1:0];
                IW'(CF_MODE):  wrap_en   <= host_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (region)
            RG_TX:  host_rdata = host_tx;
            RG_RX:  host_rdata = host_rx;
            RG_CMD: host_rdata = DW'(host_cmd);
            RG_CFG: begin
                unique case (idx)
                    IW'(CF_LEN):   host_rdata = DW'(len_cfg);
                    IW'(CF_DLY):   host_rdata = DW'(dly_cfg);
                    IW'(CF_START): host_rdata = DW'(start_ptr);
                    IW'(CF_END):   host_rdata = DW'(end_ptr);
                    IW'(CF_PTR):   host_rdata = DW'(cur_ptr);
                    IW'(CF_MODE):  host_rdata = DW'(wrap_en);
                    default:       host_rdata = '0;
                endcase
            end
            default: host_rdata = '0;
        endcase
    end

    spiq_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_we          (host_we && region == RG_TX),
        .cmd_we         (host_we && region == RG_CMD),
        .host_idx       (idx),
        .host_wdata     (host_wdata),
        .host_cmd_wdata (entry_cmd_t'(host_wdata[CMD_W-1:0])),
        .host_tx        (host_tx),
        .host_rx        (host_rx),
        .host_cmd       (host_cmd),
        .eng_idx        (cur_ptr),
        .eng_tx         (eng_tx),
        .eng_cmd        (eng_cmd),
        .rx_we          (rx_we),
        .rx_data        (rx_word)
    );

    spiq_ctrl #(
        .DEPTH(DEPTH), .DW(DW), .DLY_W(DLY_W), .PAUSE(PAUSE),
        .DEF_DLY(DEF_DLY), .MIN_LEN(MIN_LEN)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .start_ptr (start_ptr),
        .end_ptr   (end_ptr),
        .wrap_en   (wrap_en),
        .len_cfg   (len_cfg),
        .dly_cfg   (dly_cfg),
        .ptr_we    (ptr_we),
        .ptr_wdata (host_wdata[IW-1:0]),
        .eng_cmd   (eng_cmd),
        .sh_done   (sh_done),
        .cur_ptr   (cur_ptr),
        .sh_start  (sh_start),
        .sh_nbits  (sh_nbits),
        .rx_we     (rx_we),
        .cs_n      (cs_n),
        .done      (done),
        .busy      (busy)
    );

    spiq_shifter #(.DW(DW), .SCK_HALF(SCK_HALF), .MIN_LEN(MIN_LEN)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .nbits   (sh_nbits),
        .tx_word (eng_tx),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .rx_word (rx_word),
        .busy    (sh_busy),
        .done_p  (sh_done)
    );

    // R4: the serial clock only toggles while the control is in SHIFT
    a_r4_sck_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> sh_busy);

    // R6: no word shifts while the chip-select code is released
    a_r6_shift_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && cs_n == 4'hF) |-> busy);

endmodule

// File: tb/spiq_master_tb.sv
module spiq_master_tb_top;

    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        go = 1'b0;
    logic        done, busy, sck, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    int nchk = 0;
    int errs = 0;

    // Mirror of what the host has programmed, plus expected receive slots
    logic [15:0] m_tx  [16];
    logic [6:0]  m_cmd [16];
    logic [15:0] m_rx  [16];
    int          m_len = 8;
    int          m_dly = 17;
    int          m_start = 0;
    int          m_end = 0;
    bit          m_wrap = 0;

    spiq_master #(.SCK_HALF(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .go(go), .done(done),
        .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish act=hung exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        case (a[5:4])
            2'd0: m_tx[a[3:0]] = d;
            2'd2: m_cmd[a[3:0]] = d[6:0];
            2'd3: case (a[3:0])
                4'd0: m_len = (d < 8) ? 8 : ((d > 16) ? 16 : int'(d));
                4'd1: m_dly = (d[13:0] == 0) ? 1 : int'(d[13:0]);
                4'd2: m_start = int'(d[3:0]);
                4'd3: m_end = int'(d[3:0]);
                4'd5: m_wrap = d[0];
                default: ;
            endcase
            default: ;
        endcase
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    // One clock of the reference timeline, compared away from the edge
    task automatic tick(input bit e_sck, input bit e_mosi, input bit cmp_mosi,
                        input logic [3:0] e_cs, input bit e_done, input string req);
        @(negedge clk);
        chk(sck == e_sck, {req, " sck"}, sck, e_sck);
        chk(cs_n == e_cs, {req, " cs_n"}, cs_n, e_cs);
        chk(done == e_done, {req, " done"}, done, e_done);
        chk(busy == !e_done, {req, " busy"}, busy, !e_done);
        if (cmp_mosi) chk(mosi == e_mosi, {req, " mosi"}, mosi, e_mosi);
        go = 1'b0;
        host_we = 1'b0;
    endtask

    // Behavioural model: walks the queue and predicts every pin each clock
    task automatic run_model(input int redir_from, input int redir_to, input int wrap_stop_pass);
        int ptr = m_start;
        int pass = 0;
        int pend = -1;
        logic [3:0] cs_prev = 4'hF;
        go = 1'b1;
        forever begin
            logic [6:0]  cmd;
            logic [15:0] pat, mask;
            logic [3:0]  csg;
            int n, g;
            bit fin, hold;
            tick(1'b0, 1'b0, 1'b0, cs_prev, 1'b0, "R2/R5 fetch");
            cmd  = m_cmd[ptr];
            n    = cmd[5] ? m_len : 8;
            pat  = m_tx[ptr] ^ 16'h3C5A ^ 16'(pass * 4919);
            mask = (n == 16) ? 16'hFFFF : ((16'd1 << n) - 16'd1);
            for (int k = 0; k < 2 * H * n; k++) begin
                int b = k / (2 * H);
                miso = pat[n - 1 - b];
                if (k == 0 && ptr == redir_from && pend < 0 && pass == 0) begin
                    host_we = 1'b1; host_addr = 6'h34; host_wdata = 16'(redir_to);
                    pend = redir_to;
                end
                if (k == 0 && pass == wrap_stop_pass && ptr == m_start) begin
                    host_we = 1'b1; host_addr = 6'h35; host_wdata = 16'h0000;
                    m_wrap = 0;
                end
                tick(1'((k / H) % 2), m_tx[ptr][n - 1 - b], 1'b1, cmd[3:0], 1'b0, "R2/R3/R4 shift");
            end
            m_rx[ptr] = pat & mask;
            fin  = (pend < 0) && (ptr == m_end) && !m_wrap;
            hold = cmd[4] && !fin;
            g    = hold ? 17 : (cmd[6] ? m_dly : 17);
            csg  = hold ? cmd[3:0] : 4'hF;
            for (int j = 0; j < g; j++)
                tick(1'b0, 1'b0, 1'b0, csg, 1'b0, hold ? "R7 pause" : "R6 delay");
            cs_prev = csg;
            if (pend >= 0) begin
                ptr = pend; pend = -1;
            end else if (ptr == m_end) begin
                if (m_wrap) begin ptr = m_start; pass++; end
                else break;
            end else begin
                ptr = (ptr + 1) % 16;
            end
        end
        tick(1'b0, 1'b0, 1'b0, 4'hF, 1'b1, "R8 done");
    endtask

    task automatic check_rx(input int i, input string req);
        logic [15:0] v;
        rd(6'(16 + i), v);
        chk(v == m_rx[i], req, v, m_rx[i]);
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            m_tx[i] = '0; m_cmd[i] = '0; m_rx[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(mosi == 1'b0, "R1 mosi", mosi, 0);
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy", {done, busy}, 0);
        rd(6'h30, v); chk(v == 16'd8, "R1 length", v, 8);
        rd(6'h31, v); chk(v == 16'd17, "R1 delay", v, 17);
        rd(6'h34, v); chk(v == 16'd0, "R1 pointer", v, 0);

        // Mixed run: programmed 12-bit with delay, 8-bit hold, 12-bit hold, 8-bit plain
        wr(6'h30, 16'd12);
        wr(6'h31, 16'd5);
        wr(6'h00, 16'h0ABC); wr(6'h20, 16'h006E);
        wr(6'h01, 16'h005A); wr(6'h21, 16'h001D);
        wr(6'h02, 16'h0F3C); wr(6'h22, 16'h003B);
        wr(6'h03, 16'h00C3); wr(6'h23, 16'h0007);
        wr(6'h32, 16'd0); wr(6'h33, 16'd3); wr(6'h35, 16'd0);
        run_model(-1, 0, -1);
        for (int i = 0; i < 4; i++) check_rx(i, "R4 rx right-justified");
        rd(6'h34, v); chk(v == 16'd3, "R5 pointer at end entry", v, 3);

        // R3 clamping: length 20 -> 16, then length 3 -> 8
        wr(6'h30, 16'd20);
        rd(6'h30, v); chk(v == 16'd16, "R3 clamp high", v, 16);
        wr(6'h06, 16'h8001); wr(6'h26, 16'h0023);
        wr(6'h32, 16'd6); wr(6'h33, 16'd6);
        run_model(-1, 0, -1);
        check_rx(6, "R3 16-bit word");
        wr(6'h30, 16'd3);
        rd(6'h30, v); chk(v == 16'd8, "R3 clamp low", v, 8);
        wr(6'h31, 16'd0);
        rd(6'h31, v); chk(v == 16'd1, "R6 zero delay stored as 1", v, 1);
        run_model(-1, 0, -1);
        check_rx(6, "R3 clamped 8-bit word");

        // R9 wraparound pair, end entry holds; wrap cleared in the third pass
        wr(6'h31, 16'd5);
        wr(6'h04, 16'h1234); wr(6'h24, 16'h000C);
        wr(6'h05, 16'h9876); wr(6'h25, 16'h0059);
        wr(6'h32, 16'd4); wr(6'h33, 16'd5); wr(6'h35, 16'd1);
        run_model(-1, 0, 2);
        check_rx(4, "R9 latest pass start entry");
        check_rx(5, "R9 latest pass end entry");

        // R10 redirect: segment 8..10, pointer rewritten to 10 during entry 8
        wr(6'h08, 16'h0101); wr(6'h28, 16'h0001);
        wr(6'h09, 16'h0202); wr(6'h29, 16'h0002);
        wr(6'h0A, 16'h0404); wr(6'h2A, 16'h0004);
        wr(6'h32, 16'd8); wr(6'h33, 16'd10);
        run_model(8, 10, -1);
        check_rx(8, "R10 entry before redirect");
        check_rx(10, "R10 redirect target");
        check_rx(9, "R10 skipped entry untouched");
        chk(done == 1'b1, "R8 done sticky", done, 1);

        summary();
        $finish;
    end

endmodule